// File: doc/BRIEF.md
# Masked Serial Write Pointer with Reset Cache

This block is the write side of a serial field memory. On each rising write-clock edge it samples a write enable and an input enable. At the following edge it takes the word on the 12-bit data bus and stores it at the position the pointer held when the enable was seen. The word is stored only when both enables were high at that earlier edge. When the input enable was low, the slot is masked and keeps its old word. The pointer advances at every edge with the write enable high. It wraps from the last array word back to word 0, and the array depth need not be a power of two.

A standard write reset points the writer at a 12-word cache. The cache stands in for the first words after the reset, while the main array would still be busy, and writing then continues at array word 0. A block load instead moves the pointer straight to a 40-word block boundary inside the array and skips the cache. Array writes appear on a memory write port. A debug read port returns any cache or array word. The array is a behavioural memory whose depth is a parameter: a full-size field uses 245760 words, which is 6144 blocks with the highest block starting at word 245720, and the default keeps elaboration small.

Top module: `wrptr_cache`

## Requirements
- R1: After `rst_n` is released, `mem_we` is low and the pointer is at array word 0 with the cache not selected.
- R2: A word on `din` is stored at rising edge k+1 only when `we` and `ie` were both high at edge k. It goes to the pointer position held at edge k.
- R3: When `ie` was low at edge k, nothing is stored at edge k+1. The word already at that position is unchanged and `mem_we` stays low.
- R4: The pointer advances by one at each rising edge where `we` is high, and holds at every other edge.
- R5: A `wr_rst` pulse sends the next 12 words to cache entries 0 to 11 in order, and the word after those to array word 0. During the pulse `we` is ignored, and no write follows at the next edge.
- R6: A `blk_load` with `blk_idx` below DEPTH/BLOCK sets the pointer to `blk_idx`*BLOCK in the array and bypasses the cache. During the load `we` is ignored, and `mem_we` is low at the next edge.
- R7: A `blk_load` with `blk_idx` at or above DEPTH/BLOCK has no effect, and writing continues from the current pointer.
- R8: Without a reset or load, the pointer moves from array word DEPTH-1 to array word 0.
- R9: `dbg_data` returns cache entry `dbg_addr` when `dbg_cache` is 1, and array word `dbg_addr` when `dbg_cache` is 0.
- R10: `mem_addr` is always below DEPTH whenever `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wr_rst | input | 1 | Standard write reset: point at the cache start |
| we | input | 1 | Write enable: advances the pointer, qualifies the next word |
| ie | input | 1 | Input enable: a low level masks the next word |
| din | input | DW | Data word |
| blk_load | input | 1 | Load the pointer from `blk_idx` |
| blk_idx | input | BW | Block index, 40 words per block |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |
| dbg_cache | input | 1 | Debug read selects the cache |
| dbg_addr | input | AW | Debug read address |
| dbg_data | output | DW | Debug read data |

## Verification
The bench builds the block with DEPTH=120 and BLOCK=40, which gives three blocks with a 2-bit index. This brings the non-power-of-two wrap from word 119 to word 0 within a single 41-word run after loading block 2. It also leaves index 3 free as an out-of-range load. The cache keeps its full 12 entries, so the move from the cache to the array is checked at its real size.

// File: rtl/wrptr_cache.sv
module wrptr_cache #(
  parameter int DW    = 12,
  parameter int DEPTH = 2400,
  parameter int BLOCK = 40,
  parameter int CACHE = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int NBLK = DEPTH / BLOCK,
  localparam int BW   = $clog2(NBLK),
  localparam int CW   = $clog2(CACHE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rst,
  input  logic          we,
  input  logic          ie,
  input  logic [DW-1:0] din,
  input  logic          blk_load,
  input  logic [BW-1:0] blk_idx,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          dbg_cache,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);

  logic          in_c, we_q, ie_q, tgt_c;
  logic [CW-1:0] cidx, tgt_ci;
  logic [AW-1:0] aptr, tgt_a;
  logic [DW-1:0] arr   [DEPTH];
  logic [DW-1:0] cache [CACHE];

  wire blk_ok = blk_load && ({1'b0, blk_idx} < (BW+1)'(NBLK));
  wire commit = we_q & ie_q;

  assign mem_we    = commit & ~tgt_c;
  assign mem_addr  = tgt_a;
  assign mem_wdata = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_c   <= 1'b0;
      cidx   <= '0;
      aptr   <= '0;
      we_q   <= 1'b0;
      ie_q   <= 1'b0;
      tgt_c  <= 1'b0;
      tgt_ci <= '0;
      tgt_a  <= '0;
    end else if (wr_rst) begin
      in_c <= 1'b1;
      cidx <= '0;
      aptr <= '0;
      we_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (blk_ok) begin
      in_c <= 1'b0;
      aptr <= AW'(32'(blk_idx) * BLOCK);
      we_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      we_q <= we;
      ie_q <= ie;
      if (we) begin
        tgt_c  <= in_c;
        tgt_ci <= cidx;
        tgt_a  <= aptr;
        if (in_c) begin
          if (cidx == CW'(CACHE-1)) in_c <= 1'b0;
          else cidx <= cidx + 1'b1;
        end else begin
          aptr <= (aptr == AW'(DEPTH-1)) ? '0 : aptr + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) arr[tgt_a] <= din;
    if (commit && tgt_c) cache[tgt_ci] <= din;
  end

  always_comb begin
    dbg_data = '0;
    if (dbg_cache) begin
      if ({1'b0, dbg_addr} < (AW+1)'(CACHE)) dbg_data = cache[dbg_addr[CW-1:0]];
    end else begin
      if ({1'b0, dbg_addr} < (AW+1)'(DEPTH)) dbg_data = arr[dbg_addr];
    end
  end

endmodule

module wrptr_cache_chk #(
  parameter int DEPTH = 2400,
  parameter int AW    = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_rst,
  input logic          we,
  input logic          ie,
  input logic          blk_ok,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);

  // R2
  commit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(we) && $past(ie)));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie && !wr_rst && !blk_ok) |=> !mem_we);

  // R5
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rst |=> !mem_we);

  // R6
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ok |=> !mem_we);

  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} < (AW+1)'(DEPTH)));

endmodule

bind wrptr_cache wrptr_cache_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .we(we), .ie(ie),
  .blk_ok(blk_ok), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/wrptr_cache_bench.sv
`timescale 1ns/1ps
module wrptr_cache_bench;
  localparam int DW = 12, DEPTH = 120, BLOCK = 40, CACHE = 12;
  localparam int AW = $clog2(DEPTH), BW = 2;

  // {we, ie, din}
  localparam logic [13:0] VEC [20] = '{
    14'h3A01, 14'h3A02, 14'h2A03, 14'h3A04, 14'h0A05,
    14'h0A06, 14'h3A07, 14'h1A08, 14'h3A09, 14'h2A0A,
    14'h2A0B, 14'h3A0C, 14'h3A0D, 14'h3A0E, 14'h3A0F,
    14'h3A10, 14'h3A11, 14'h0A12, 14'h3A13, 14'h0A14 };

  logic clk = 0, rst_n = 0, wr_rst = 0, we = 0, ie = 0, blk_load = 0, dbg_cache = 0;
  logic [DW-1:0] din = '0;
  logic [BW-1:0] blk_idx = '0;
  logic [AW-1:0] dbg_addr = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, dbg_data;

  always #2 clk = ~clk;

  wrptr_cache #(.DW(DW), .DEPTH(DEPTH), .BLOCK(BLOCK), .CACHE(CACHE)) u_wrptr_cache (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .we(we), .ie(ie), .din(din),
    .blk_load(blk_load), .blk_idx(blk_idx), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .dbg_cache(dbg_cache), .dbg_addr(dbg_addr), .dbg_data(dbg_data));

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mc [CACHE];
  logic [DW-1:0] ma [DEPTH];
  bit vc [CACHE];
  bit va [DEPTH];
  bit m_c = 0, p_we = 0, p_ie = 0, p_c = 0;
  int m_ci = 0, m_a = 0, p_ci = 0, p_a = 0;

  task automatic step(input bit w, input bit e, input logic [DW-1:0] d,
                      input bit r = 0, input bit l = 0, input int b = 0);
    @(negedge clk);
    we = w; ie = e; din = d; wr_rst = r; blk_load = l; blk_idx = BW'(b);
    if (p_we && p_ie) begin
      if (p_c) begin mc[p_ci] = d; vc[p_ci] = 1; end
      else begin ma[p_a] = d; va[p_a] = 1; end
    end
    if (r) begin
      m_c = 1; m_ci = 0; m_a = 0; p_we = 0; p_ie = 0;
    end else if (l && b < DEPTH / BLOCK) begin
      m_c = 0; m_a = b * BLOCK; p_we = 0; p_ie = 0;
    end else begin
      p_we = w; p_ie = e;
      if (w) begin
        p_c = m_c; p_ci = m_ci; p_a = m_a;
        if (m_c) begin
          if (m_ci == CACHE - 1) m_c = 0; else m_ci++;
        end else m_a = (m_a == DEPTH - 1) ? 0 : m_a + 1;
      end
    end
  endtask

  task automatic settle();
    step(0, 0, '0);
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input bit c, input int a, output logic [DW-1:0] v);
    dbg_cache = c; dbg_addr = AW'(a); #1; v = dbg_data;
  endtask

  task automatic cmp_all(input string req);
    logic [DW-1:0] v;
    for (int i = 0; i < CACHE; i++) if (vc[i]) begin rd(1, i, v); chk(req, v, mc[i]); end
    for (int i = 0; i < DEPTH; i++) if (va[i]) begin rd(0, i, v); chk(req, v, ma[i]); end
  endtask

  initial begin
    #(4 * 5000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    n_chk++;
    if (mem_we !== 1'b0) begin n_fail++; $display("FAIL R1: actual mem_we %b expected 0", mem_we); end

    // R1: first word after power-up goes to array word 0
    step(1, 1, 12'h0AA);
    step(0, 0, 12'h055);
    settle();
    rd(0, 0, v); chk("R1", v, 12'h055);

    // R5: cache fill then array word 0
    step(0, 0, '0, 1);
    for (int i = 0; i < 15; i++) step(1, 1, DW'(12'h100 + i));
    settle();
    rd(1, 0, v);  chk("R5 R9", v, 12'h101);
    rd(1, 11, v); chk("R5 R9", v, 12'h10C);
    rd(0, 0, v);  chk("R5", v, 12'h10D);
    rd(0, 1, v);  chk("R5", v, 12'h10E);

    // R2 R3 R4: vector walk after a fresh write reset
    step(0, 0, '0, 1);
    for (int i = 0; i < 20; i++) step(VEC[i][13], VEC[i][12], VEC[i][11:0]);
    settle();
    cmp_all("R2 R3 R4");

    // R6 R8: block 2 load, run across the wrap
    step(0, 0, '0, 0, 1, 2);
    for (int i = 0; i <= 40; i++) step(1, 1, DW'(12'h200 + i));
    step(0, 0, 12'h2FF);
    settle();
    rd(0, 80, v);  chk("R6", v, 12'h201);
    rd(0, 119, v); chk("R8", v, 12'h228);
    rd(0, 0, v);   chk("R8", v, 12'h2FF);
    rd(1, 0, v);   chk("R6", v, mc[0]);

    // R7: out-of-range block load ignored, pointer stays at word 1
    step(0, 0, '0, 0, 1, 3);
    step(1, 1, 12'h3AA);
    step(0, 0, 12'h3AB);
    settle();
    rd(0, 1, v); chk("R7", v, 12'h3AB);

    // R3: masked slot keeps its old word, pointer still moves
    rd(0, 2, keep);
    step(1, 0, 12'h3CC);
    step(1, 1, 12'h3CD);
    step(0, 0, 12'h3CE);
    settle();
    rd(0, 2, v); chk("R3", v, keep);
    rd(0, 3, v); chk("R4", v, 12'h3CE);

    cmp_all("R2 R9");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule